// File: doc/BRIEF.md
# Reference-Counted Isolation Power Sequencer

Several physical-layer users share three isolation and power-gating controls: a core-voltage-down bit, an early clamp enable and a main clamp enable. Each user sends an init request when it starts using the shared pads and an exit request when it stops. The block keeps a count of active users. The first init releases the isolation with a timed three-step power-up sequence. The last exit applies it again with the same steps in reverse order. Requests in between only move the count.

Each request enters a small in-order queue. The block takes one request per cycle from the queue, and only while no sequence is running. A request that arrives during a sequence therefore waits, and all requests are handled in the order they arrived. The settle time between steps is a parameter in clock cycles. Its default is 100 µs at the configured clock frequency. An exit that arrives when no user is active raises a one-cycle warning pulse and changes nothing else.

Top module: `clamp_refcnt_seq`

## Requirements
- R1: After reset, vcore_down, clamp_early and clamp_en are all 1. use_count is 0, busy, done and underflow_warn are 0, and req_ready is 1.
- R2: When the block accepts an init (req_exit=0) at count zero, the count goes to 1. clamp_en falls at the accept edge, clamp_early falls SETTLE_CYC cycles later, and vcore_down falls another SETTLE_CYC cycles after that.
- R3: When the block accepts an exit (req_exit=1) at count one, the count goes to 0. vcore_down rises at the accept edge, clamp_early rises SETTLE_CYC cycles later, and clamp_en rises another SETTLE_CYC cycles after that.
- R4: An accepted init at a nonzero count below the maximum increments the count. An accepted exit at a count of two or more decrements it. Neither changes the three control bits.
- R5: busy is 1 from the accept edge of a sequence until the edge of its final step. done is a one-cycle pulse at that final edge, and busy is 0 at the same edge.
- R6: An exit accepted at count zero gives a one-cycle underflow_warn pulse. The count and the control bits are left unchanged.
- R7: A request is taken in on an edge where req_valid and req_ready are both 1. It is accepted no earlier than the following edge. The block accepts at most one request per edge, only while busy is 0, and in arrival order.
- R8: req_ready is 0 while QDEPTH requests are waiting. A request presented while req_ready is 0 is dropped.
- R9: An init accepted when the count is all ones leaves the count and the control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_exit | input | 1 | Request kind: 0 = init, 1 = exit |
| req_ready | output | 1 | The queue has room for a request |
| vcore_down | output | 1 | Core voltage down control |
| clamp_early | output | 1 | Early clamp enable |
| clamp_en | output | 1 | Main clamp enable |
| busy | output | 1 | A power sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| underflow_warn | output | 1 | One-cycle pulse for an exit at count zero |
| use_count | output | CNT_W | Number of active users |

## Verification
A wrong use count shows up at the ports only later. It appears either in use_count or when a sequence starts on the wrong request, which can be many requests after the fault. For this reason the bench compares every output on every cycle against its own model. Timer and step errors move a control-bit edge by one or more cycles, and the bench sees this within one settle window. A queue ordering fault shows up as a sequence that starts or fails to start, or as a warning pulse on the wrong accept edge. Random traffic that is weighted toward init and then toward exit drives the count across zero many times. Directed cases cover the empty count, a full queue and a saturated count.

// File: rtl/clamp_seq_pkg.sv
package clamp_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP2 = 2'd1,
    ST_STEP3 = 2'd2
  } seq_state_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } seq_dir_e;

  typedef struct packed {
    logic vcore_down;
    logic clamp_early;
    logic clamp_en;
  } iso_bits_t;

  localparam iso_bits_t ISO_ALL_ON = '{vcore_down: 1'b1, clamp_early: 1'b1, clamp_en: 1'b1};

endpackage

// File: rtl/clamp_req_fifo.sv
module clamp_req_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [FW-1:0] FULL_LVL = FW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [FW-1:0] fill_q, fill_d;
  logic push_ok, pop_ok;

  assign empty   = (fill_q == '0);
  assign full    = (fill_q == FULL_LVL);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign pop_data = mem[rd_q];

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    fill_d = fill_q;
    if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_d;
      if (pop_ok)  rd_q <= rd_d;
      if (push_ok || pop_ok) fill_q <= fill_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok && (wr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) mem[g] <= push_data;
    end
  end

endmodule

// File: rtl/clamp_use_counter.sv
module clamp_use_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             take_exit,
  output logic [CNT_W-1:0] count,
  output logic             start_up,
  output logic             start_down,
  output logic             warn
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic warn_q, warn_d;
  logic is_zero, is_one, is_max;

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_ONE);
  assign is_max  = (cnt_q == CNT_MAX);

  assign start_up   = take && !take_exit && is_zero;
  assign start_down = take && take_exit && is_one;

  always_comb begin
    cnt_d  = cnt_q;
    warn_d = 1'b0;
    if (take) begin
      if (!take_exit) begin
        if (!is_max) cnt_d = cnt_q + 1'b1;
      end else if (is_zero) begin
        warn_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      if (take) cnt_q <= cnt_d;
      warn_q <= warn_d;
    end
  end

  assign count = cnt_q;
  assign warn  = warn_q;

endmodule

// File: rtl/clamp_step_seq.sv
module clamp_step_seq
  import clamp_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 5000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_up,
  input  logic      start_down,
  output iso_bits_t bits,
  output logic      busy,
  output logic      done
);
  localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(SETTLE_CYC - 1);

  seq_state_e state_q, state_d;
  seq_dir_e   dir_q, dir_d;
  logic [TW-1:0] tmr_q, tmr_d;
  iso_bits_t  bits_q, bits_d;
  logic done_q, done_d;
  logic tick, tmr_en;

  assign tick   = (tmr_q == '0);
  assign tmr_en = (state_q != ST_IDLE) || start_up || start_down;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    tmr_d   = tmr_q;
    bits_d  = bits_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_up) begin
          bits_d.clamp_en = 1'b0;
          dir_d   = DIR_UP;
          state_d = ST_STEP2;
          tmr_d   = RELOAD;
        end else if (start_down) begin
          bits_d.vcore_down = 1'b1;
          dir_d   = DIR_DOWN;
          state_d = ST_STEP2;
          tmr_d   = RELOAD;
        end
      end
      ST_STEP2: begin
        if (tick) begin
          bits_d.clamp_early = (dir_q == DIR_DOWN);
          state_d = ST_STEP3;
          tmr_d   = RELOAD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_STEP3: begin
        if (tick) begin
          if (dir_q == DIR_UP) bits_d.vcore_down = 1'b0;
          else                 bits_d.clamp_en   = 1'b1;
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_UP;
      tmr_q   <= '0;
      bits_q  <= ISO_ALL_ON;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      done_q  <= done_d;
      if (start_up || start_down) dir_q <= dir_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign bits = bits_q;
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/clamp_refcnt_seq.sv
module clamp_refcnt_seq
  import clamp_seq_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SETTLE_US  = 100,
  parameter int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US,
  parameter int QDEPTH     = 4,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_exit,
  output logic             req_ready,
  output logic             vcore_down,
  output logic             clamp_early,
  output logic             clamp_en,
  output logic             busy,
  output logic             done,
  output logic             underflow_warn,
  output logic [CNT_W-1:0] use_count
);
  logic q_empty, q_full, q_head;
  logic take, start_up, start_down, seq_busy;
  iso_bits_t iso;

  assign req_ready = !q_full;
  assign take      = !q_empty && !seq_busy;

  clamp_req_fifo #(.DEPTH(QDEPTH), .WIDTH(1)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid),
    .push_data (req_exit),
    .pop       (take),
    .pop_data  (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  clamp_use_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_exit  (q_head),
    .count      (use_count),
    .start_up   (start_up),
    .start_down (start_down),
    .warn       (underflow_warn)
  );

  clamp_step_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_up   (start_up),
    .start_down (start_down),
    .bits       (iso),
    .busy       (seq_busy),
    .done       (done)
  );

  assign busy        = seq_busy;
  assign vcore_down  = iso.vcore_down;
  assign clamp_early = iso.clamp_early;
  assign clamp_en    = iso.clamp_en;

endmodule

// File: rtl/clamp_refcnt_seq_chk.sv
module clamp_refcnt_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vcore_down,
  input logic             clamp_early,
  input logic             clamp_en,
  input logic             busy,
  input logic             done,
  input logic             underflow_warn,
  input logic [CNT_W-1:0] use_count
);
  a_r2_early_after_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_early) |-> !clamp_en);

  a_r2_vcore_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcore_down) |-> (!clamp_early && !clamp_en && done));

  a_r3_clamp_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_en) |-> (vcore_down && clamp_early && done));

  a_r3_early_after_vcore: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_early) |-> vcore_down);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r4_bits_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(vcore_down) && $stable(clamp_early) && $stable(clamp_en)));

  a_r4_count_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(use_count) |-> ((use_count == $past(use_count) + CNT_W'(1)) ||
                             (use_count == $past(use_count) - CNT_W'(1))));

  a_r6_warn_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_warn |-> (use_count == '0 && !busy));

  a_r7_count_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(use_count));

endmodule

bind clamp_refcnt_seq clamp_refcnt_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .vcore_down     (vcore_down),
  .clamp_early    (clamp_early),
  .clamp_en       (clamp_en),
  .busy           (busy),
  .done           (done),
  .underflow_warn (underflow_warn),
  .use_count      (use_count)
);

// File: tb/clamp_refcnt_seq_bench.sv
module clamp_refcnt_seq_bench;
  localparam int S   = 6;
  localparam int QD  = 4;
  localparam int CW  = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk, rst_n, req_valid, req_exit;
  logic req_ready, vcore_down, clamp_early, clamp_en, busy, done, underflow_warn;
  logic [CW-1:0] use_count;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  clamp_refcnt_seq #(.CLK_HZ(50_000_000), .SETTLE_US(100), .SETTLE_CYC(S),
                     .QDEPTH(QD), .CNT_W(CW)) u_clamp_refcnt_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_exit(req_exit),
    .req_ready(req_ready), .vcore_down(vcore_down), .clamp_early(clamp_early),
    .clamp_en(clamp_en), .busy(busy), .done(done),
    .underflow_warn(underflow_warn), .use_count(use_count));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench model built from the requirements
  bit mq[$];
  int m_cnt, m_state, m_tmr;
  bit m_dir, m_vc, m_ce, m_cl, m_warn, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_cnt = 0; m_state = 0; m_tmr = 0; m_dir = 0;
      m_vc = 1; m_ce = 1; m_cl = 1; m_warn = 0; m_done = 0;
    end else begin
      bit pop, push_ok, k;
      pop     = (mq.size() > 0) && (m_state == 0);
      push_ok = req_valid && (mq.size() < QD);
      m_warn = 0;
      m_done = 0;
      if (m_state != 0) begin
        if (m_tmr == 0) begin
          if (m_state == 1) begin
            m_ce = m_dir; m_state = 2; m_tmr = S - 1;
          end else begin
            if (!m_dir) m_vc = 0; else m_cl = 1;
            m_state = 0; m_done = 1;
          end
        end else m_tmr--;
      end
      if (pop) begin
        k = mq.pop_front();
        if (!k) begin
          if (m_cnt == 0) begin
            m_cnt = 1; m_dir = 0; m_cl = 0; m_state = 1; m_tmr = S - 1;
          end else if (m_cnt != CMAX) m_cnt++;
        end else begin
          if (m_cnt == 0) m_warn = 1;
          else if (m_cnt == 1) begin
            m_cnt = 0; m_dir = 1; m_vc = 1; m_state = 1; m_tmr = S - 1;
          end else m_cnt--;
        end
      end
      if (push_ok) mq.push_back(req_exit);
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2/R3", "vcore_down",  vcore_down,  m_vc);
      check("R2/R3", "clamp_early", clamp_early, m_ce);
      check("R2/R3", "clamp_en",    clamp_en,    m_cl);
      check("R5", "busy", busy, (m_state != 0));
      check("R5", "done", done, m_done);
      check("R6", "underflow_warn", underflow_warn, m_warn);
      check("R4/R9", "use_count", use_count, m_cnt);
      check("R8", "req_ready", req_ready, (mq.size() < QD));
    end
  end

  task automatic send(bit ex);
    @(negedge clk);
    req_valid = 1'b1;
    req_exit  = ex;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (mq.size() > 0 || m_state != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values stated literally
    check("R1", "vcore_down",  vcore_down, 1);
    check("R1", "clamp_early", clamp_early, 1);
    check("R1", "clamp_en",    clamp_en, 1);
    check("R1", "use_count",   use_count, 0);
    check("R1", "busy/done/warn", {busy, done, underflow_warn}, 0);
    check("R1", "req_ready",   req_ready, 1);

    // R6: exit at zero
    send(1'b1); settle();
    // R2: first init powers up
    send(1'b0);
    @(negedge clk);
    check("R2", "clamp_en low after accept", clamp_en, 0);
    check("R2", "clamp_early still high", clamp_early, 1);
    settle();
    check("R2", "all released", {vcore_down, clamp_early, clamp_en}, 0);
    // R4: extra users
    send(1'b0); send(1'b0); settle();
    check("R4", "count three", use_count, 3);
    send(1'b1); send(1'b1); settle();
    check("R4", "bits unchanged", {vcore_down, clamp_early, clamp_en}, 0);
    // R3: last exit
    send(1'b1); settle();
    check("R3", "all clamped", {vcore_down, clamp_early, clamp_en}, 7);
    // R7/R8: burst while busy fills the queue
    @(negedge clk); req_valid = 1'b1; req_exit = 1'b0;
    repeat (QD + 3) @(negedge clk);
    req_valid = 1'b0;
    settle();
    // R9: saturate count
    for (int i = 0; i < CMAX + 2; i++) send(1'b0);
    settle();
    check("R9", "count saturates", use_count, CMAX);
    for (int i = 0; i < CMAX + 1; i++) send(1'b1);
    settle();
    // random phases, init-heavy then exit-heavy
    for (int ph = 0; ph < 6; ph++) begin
      int pe;
      pe = (ph % 2 == 0) ? 35 : 65;
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        req_valid = ($urandom % 100) < 40;
        req_exit  = ($urandom % 100) < pe;
      end
      req_valid = 1'b0;
    end
    settle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule